// File: doc/BRIEF.md
# Strobed Parallel Register Port

This block is the device side of a narrow register link driven from one 8-bit host output port. The host frames every word itself. The top bit of the port is a strobe. The next bit marks whether the word names a register or carries a value. The low six bits hold either a register number or a 6-bit value. The host first sets up a word with the strobe low and then raises the strobe. The rising strobe edge captures the word. The port bits are brought into the local clock domain through a synchronizer, and edges are found on the synchronized strobe.

A write is a register-select word followed by one data word. A read is a select word on its own; the host then samples the read-back byte. The block holds a bank of sixty-four 6-bit registers. Register 0x20 is a read-only identity register. It returns the code 0x55 once the surrounding logic reports that it is configured, and it carries an interrupt flag in its top bit. Register 0x07 is a global unmute control.

Registers 0 to 3 stage wide routing entries. Registers 0 and 1 give the destination (group and slot), and registers 2 and 3 give the 12-bit source. Writing register 3 commits the entry into a small routing table, which the audio side reads through a lookup port.

Top module: `strobe_regport`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `unmute` is 0 and every routing entry reads 0.
- R2: A port word is taken only on a rising edge of port bit 7. A word with bit 6 = 1 selects the register numbered by bits 5:0. A following word with bit 6 = 0 writes bits 5:0 into that register.
- R3: After a select word, `rd_data` shows {2'b00, register contents} for every register except the identity register.
- R4: A data word with no pending select is ignored: either no select has been sent since reset, or the last select has already been used by a write.
- R5: A change of bits 6:0 while bit 7 stays high captures nothing. Only the word present at the rising edge counts.
- R6: The identity register 0x20 reads {irq_in, 7'h55} while `cfg_done` = 1 and {irq_in, 7'h00} while `cfg_done` = 0. Writes to it have no effect.
- R7: `unmute` equals bit 0 of register 0x07, so writing 1 unmutes and writing 0 mutes.
- R8: A write to register 3 with value V commits the routing entry at group = register 0 and slot = register 1 with source {register 2, V}. It is read as `route_src` for that group and slot.
- R9: A commit whose group is 4 or more, or whose slot is 8 or more, changes no routing entry. Writes to registers 0 to 2 alone never change the table.
- R10: When two select words arrive in a row, the later one decides which register the next data word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_port | input | 8 | Host word: bit 7 strobe, bit 6 select marker, bits 5:0 field |
| cfg_done | input | 1 | Surrounding logic configured; enables the identity code |
| irq_in | input | 1 | Interrupt flag returned in bit 7 of the identity read |
| route_grp | input | 2 | Routing lookup group |
| route_slot | input | 3 | Routing lookup slot |
| rd_data | output | 8 | Read-back byte for the currently selected register |
| unmute | output | 1 | Global unmute |
| route_src | output | 12 | Source held in the looked-up routing entry |

## Verification
The bench sweeps all sixty-four registers with computed values and fills all thirty-two routing entries. These sweeps catch a bank that aliases addresses and a table that drops or misplaces entries. It then targets framing faults. A data word with no select in front of it would corrupt a register if a design kept the select live after a write. Bits that move while the strobe is held high would add spurious writes if a design latched on level instead of edge. Out-of-range routing destinations would overwrite a real entry if a design decoded only the low bits. The identity register is checked with `cfg_done` off and on and after an attempted write, so a design that stored the code or let it be overwritten is caught.

// File: rtl/regport_pkg.sv
// Shared constants and types for the strobed register port.
// Assumes an 8-bit host word: strobe, select marker, 6-bit field.
package regport_pkg;
    localparam int PORT_W    = 8;
    localparam int STB_BIT   = 7;
    localparam int SEL_BIT   = 6;
    localparam int FIELD_W   = 6;

    // One captured host word after the strobe edge.
    typedef struct packed {
        logic                is_sel;
        logic [FIELD_W-1:0]  field;
    } host_word_t;
endpackage

// File: rtl/regport_strobe_sync.sv
// Brings the host port into the local clock domain and emits a one-cycle
// pulse with the captured word on each rising edge of the strobe bit.
// Assumes the host holds the word steady before raising the strobe.
module regport_strobe_sync
    import regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    output logic              word_valid,
    output host_word_t        word_out
);
    logic [SYNC_STAGES-1:0][PORT_W-1:0] chain_q;
    logic                               stb_prev_q;
    logic [PORT_W-1:0]                  synced;

    assign synced = chain_q[SYNC_STAGES-1];

    // Synchronizer chain across all port bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= port_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Previous synchronized strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev_q <= 1'b0;
        else        stb_prev_q <= synced[STB_BIT];
    end

    assign word_valid     = synced[STB_BIT] & ~stb_prev_q;
    assign word_out.is_sel = synced[SEL_BIT];
    assign word_out.field  = synced[FIELD_W-1:0];

    AST_ONE_PULSE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R5
endmodule

// File: rtl/regport_framer.sv
// Pairs select words with data words. A select arms one write; a data
// word with no armed select is dropped. The last select also sets the
// read address, which persists until the next select.
module regport_framer
    import regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_valid,
    input  host_word_t         word_in,
    output logic               wr_en,
    output logic [FIELD_W-1:0] wr_addr,
    output logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] rd_addr
);
    logic               armed_q;
    logic [FIELD_W-1:0] addr_q;

    // Track the selected register and whether a write is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else if (word_valid && word_in.is_sel) begin
            armed_q <= 1'b1;
            addr_q  <= word_in.field;
        end else if (wr_en) begin
            armed_q <= 1'b0;
        end
    end

    assign wr_en   = word_valid && !word_in.is_sel && armed_q;
    assign wr_addr = addr_q;
    assign wr_data = word_in.field;
    assign rd_addr = addr_q;

    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4
    AST_ADDR_ONLY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(rd_addr)); // R10
endmodule

// File: rtl/regport_bank.sv
// Bank of 6-bit registers with a read-only identity register and a
// global unmute bit. Drives the read-back byte for the selected address
// and exposes the routing staging registers and a commit strobe.
module regport_bank
    import regport_pkg::*;
#(
    parameter int                 ADDR_W      = FIELD_W,
    parameter int                 REG_W       = FIELD_W,
    parameter logic [ADDR_W-1:0]  ID_ADDR     = 6'h20,
    parameter logic [ADDR_W-1:0]  UNMUTE_ADDR = 6'h07,
    parameter logic [6:0]         ID_CODE     = 7'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              cfg_done,
    input  logic              irq_in,
    output logic [7:0]        rd_data,
    output logic              unmute,
    output logic [REG_W-1:0]  stage_dst_hi,
    output logic [REG_W-1:0]  stage_dst_lo,
    output logic [REG_W-1:0]  stage_src_hi,
    output logic              commit,
    output logic [REG_W-1:0]  commit_src_lo
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(3);

    logic [DEPTH-1:0][REG_W-1:0] bank_q;

    // Register storage; the identity slot is never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr_en && wr_addr != ID_ADDR) begin
            bank_q[wr_addr] <= wr_data;
        end
    end

    // Read-back byte for the selected address.
    always_comb begin
        if (rd_addr == ID_ADDR) begin
            rd_data = {irq_in, cfg_done ? ID_CODE : 7'h00};
        end else begin
            rd_data = {{(8-REG_W){1'b0}}, bank_q[rd_addr]};
        end
    end

    assign unmute        = bank_q[UNMUTE_ADDR][0];
    assign stage_dst_hi  = bank_q[0];
    assign stage_dst_lo  = bank_q[1];
    assign stage_src_hi  = bank_q[2];
    assign commit        = wr_en && (wr_addr == COMMIT_ADDR);
    assign commit_src_lo = wr_data;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q)); // R2
    AST_UNMUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == UNMUTE_ADDR) |=> $stable(unmute)); // R7
    AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ID_ADDR) |=> $stable(bank_q)); // R6
endmodule

// File: rtl/regport_route_table.sv
// Routing table of GROUPS x SLOTS entries, each holding a 2*REG_W source.
// An entry is written only when the committed destination matches it
// exactly; destinations outside the table match nothing.
module regport_route_table #(
    parameter int REG_W  = 6,
    parameter int GROUPS = 4,
    parameter int SLOTS  = 8,
    parameter int GRP_W  = $clog2(GROUPS),
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [REG_W-1:0]   dst_hi,
    input  logic [REG_W-1:0]   dst_lo,
    input  logic [REG_W-1:0]   src_hi,
    input  logic [REG_W-1:0]   src_lo,
    input  logic [GRP_W-1:0]   look_grp,
    input  logic [SLOT_W-1:0]  look_slot,
    output logic [2*REG_W-1:0] look_src
);
    localparam int ENTRIES = GROUPS * SLOTS;
    localparam int SRC_W   = 2 * REG_W;

    logic [ENTRIES-1:0][SRC_W-1:0] table_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam logic [REG_W-1:0] G_C = REG_W'(g);
            localparam logic [REG_W-1:0] S_C = REG_W'(s);
            logic hit;
            assign hit = commit && (dst_hi == G_C) && (dst_lo == S_C);
            // Capture the source when this entry's destination commits.
            always_ff @(posedge clk) begin
                if (!rst_n)   table_q[g*SLOTS+s] <= '0;
                else if (hit) table_q[g*SLOTS+s] <= {src_hi, src_lo};
            end
        end
    end

    // Lookup mux for the requested group and slot.
    always_comb begin
        look_src = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (look_grp == GRP_W'(g) && look_slot == SLOT_W'(s)) begin
                    look_src = table_q[g*SLOTS+s];
                end
            end
        end
    end

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(table_q)); // R9
endmodule

// File: rtl/strobe_regport.sv
// Top of the strobed register port: synchronizer and edge detect, word
// framer, register bank and routing table.
// Assumes a host that sets each word up with the strobe low before raising it.
module strobe_regport
    import regport_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int SLOTS  = 8,
    parameter int GRP_W  = $clog2(GROUPS),
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    host_port,
    input  logic                 cfg_done,
    input  logic                 irq_in,
    input  logic [GRP_W-1:0]     route_grp,
    input  logic [SLOT_W-1:0]    route_slot,
    output logic [7:0]           rd_data,
    output logic                 unmute,
    output logic [2*FIELD_W-1:0] route_src
);
    host_word_t         word;
    logic               word_valid;
    logic               wr_en;
    logic [FIELD_W-1:0] wr_addr, wr_data, rd_addr;
    logic [FIELD_W-1:0] dst_hi, dst_lo, src_hi, src_lo;
    logic               commit;

    regport_strobe_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .port_in(host_port),
        .word_valid(word_valid), .word_out(word)
    );

    regport_framer u_framer (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
    );

    regport_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cfg_done(cfg_done),
        .irq_in(irq_in), .rd_data(rd_data), .unmute(unmute),
        .stage_dst_hi(dst_hi), .stage_dst_lo(dst_lo), .stage_src_hi(src_hi),
        .commit(commit), .commit_src_lo(src_lo)
    );

    regport_route_table #(
        .REG_W(FIELD_W), .GROUPS(GROUPS), .SLOTS(SLOTS),
        .GRP_W(GRP_W), .SLOT_W(SLOT_W)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .dst_hi(dst_hi), .dst_lo(dst_lo), .src_hi(src_hi), .src_lo(src_lo),
        .look_grp(route_grp), .look_slot(route_slot), .look_src(route_src)
    );
endmodule

// File: tb/strobe_regport_bench.sv
module strobe_regport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_port = 8'h00;
    logic        cfg_done = 1'b0;
    logic        irq_in = 1'b0;
    logic [1:0]  route_grp = '0;
    logic [2:0]  route_slot = '0;
    logic [7:0]  rd_data;
    logic        unmute;
    logic [11:0] route_src;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    strobe_regport u_strobe_regport (
        .clk(clk), .rst_n(rst_n), .host_port(host_port), .cfg_done(cfg_done),
        .irq_in(irq_in), .route_grp(route_grp), .route_slot(route_slot),
        .rd_data(rd_data), .unmute(unmute), .route_src(route_src)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present a word with the strobe low, then raise the strobe.
    task automatic send_word(input logic [6:0] w);
        @(negedge clk) host_port = {1'b0, w};
        repeat (3) @(negedge clk);
        host_port = {1'b1, w};
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [5:0] d);
        send_word({1'b1, a});
        send_word({1'b0, d});
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
        send_word({1'b1, a});
        check(req, rd_data, exp);
    endtask

    task automatic look_check(input string req, input int g, input int s, input logic [11:0] exp);
        @(negedge clk);
        route_grp = 2'(g);
        route_slot = 3'(s);
        @(negedge clk);
        check(req, route_src, exp);
    endtask

    function automatic logic [5:0] pat(input int a);
        return 6'((a * 7 + 3) & 63);
    endfunction

    function automatic logic [11:0] rsrc(input int g, input int s);
        return {6'((g * 5 + s + 1) & 63), 6'((s * 9 + g * 3 + 7) & 63)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 unmute", unmute, 1'b0);
        look_check("R1 route", 3, 7, 12'h000);

        // R4 data word with nothing selected since reset
        send_word(7'h15);
        rd_check("R4 no-select data", 6'd0, 8'h00);

        // R2/R3 sweep of every register
        for (int a = 0; a < 64; a++) wr(6'(a), pat(a));
        for (int a = 0; a < 64; a++) begin
            if (a != 32) rd_check("R3 sweep", 6'(a), {2'b00, pat(a)});
        end
        check("R7 unmute after sweep", unmute, pat(7) & 6'd1);

        // R6 identity register
        rd_check("R6 id unconfigured", 6'h20, 8'h00);
        cfg_done = 1'b1;
        irq_in = 1'b1;
        @(negedge clk);
        check("R6 id configured irq", rd_data, 8'hD5);
        wr(6'h20, 6'h3f);
        irq_in = 1'b0;
        rd_check("R6 id after write", 6'h20, 8'h55);

        // R7 unmute control
        wr(6'h07, 6'h01);
        check("R7 unmute on", unmute, 1'b1);
        wr(6'h07, 6'h00);
        check("R7 unmute off", unmute, 1'b0);
        wr(6'h07, 6'h3e);
        check("R7 even value mutes", unmute, 1'b0);

        // R4 a second data word after a write is dropped
        wr(6'd9, 6'h11);
        send_word(7'h22);
        rd_check("R4 extra data", 6'd9, 8'h11);

        // R10 the later select decides
        send_word(7'h40 | 7'd10);
        send_word(7'h40 | 7'd11);
        send_word(7'h2a);
        rd_check("R10 last select", 6'd11, 8'h2a);
        rd_check("R10 earlier select untouched", 6'd10, {2'b00, pat(10)});

        // R5 bits moving while the strobe stays high
        wr(6'd5, 6'h01);
        wr(6'd6, 6'h02);
        send_word(7'h40 | 7'd5);
        @(negedge clk) host_port = 8'hC6;
        repeat (6) @(negedge clk);
        host_port = 8'h9f;
        repeat (6) @(negedge clk);
        send_word(7'h0c);
        rd_check("R5 reg6 unchanged", 6'd6, 8'h02);
        rd_check("R5 reg5 written", 6'd5, 8'h0c);

        // R8 fill the routing table
        for (int g = 0; g < 4; g++) begin
            for (int s = 0; s < 8; s++) begin
                logic [11:0] v;
                v = rsrc(g, s);
                wr(6'd0, 6'(g));
                wr(6'd1, 6'(s));
                wr(6'd2, v[11:6]);
                wr(6'd3, v[5:0]);
            end
        end
        for (int g = 0; g < 4; g++) begin
            for (int s = 0; s < 8; s++) look_check("R8 route entry", g, s, rsrc(g, s));
        end

        // R9 out-of-range destinations and staging-only writes
        wr(6'd0, 6'd5); wr(6'd1, 6'd2); wr(6'd2, 6'h3f); wr(6'd3, 6'h3f);
        look_check("R9 group out of range", 1, 2, rsrc(1, 2));
        wr(6'd0, 6'd2); wr(6'd1, 6'd10); wr(6'd2, 6'h3f); wr(6'd3, 6'h3f);
        look_check("R9 slot out of range", 2, 2, rsrc(2, 2));
        wr(6'd0, 6'd0); wr(6'd1, 6'd0); wr(6'd2, 6'h15);
        look_check("R9 staging only", 0, 0, rsrc(0, 0));
        wr(6'd3, 6'h2b);
        look_check("R8 commit uses staged values", 0, 0, {6'h15, 6'h2b});

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule